// File: doc/BRIEF.md
# Colour Palette Host Access Sequencer

This block sits between a byte-wide host register bus and a 256-entry colour lookup table. The host picks an entry with an index register and then moves its colour bytes through one data port. Each access to the port moves a component pointer on by one step: red, then green, then blue, and in four-byte format also an extra byte. When the last component of the entry has been accessed, the pointer returns to red and the entry index goes up by one. Software can therefore load or dump the whole table as one run of byte accesses after a single index write.

A second index register also sets the index, and at the same time copies the red, green and blue bytes of the addressed entry into three prefetch registers. The host can then read these registers later without moving the pointer. On the display side, each pixel byte is ANDed with a mask register and used as the lookup address. The lookup has its own read port, so it returns the entry's colour one cycle later, and host traffic never stalls it.

Top module: `pal_port_seq`

## Requirements
- R1: While reset is asserted the entry index is 0, the component pointer is red, the format bit is 0, the mask is 0xFF, the prefetch bytes are 0, and busRdata and lutRgb are 0.
- R2: Register map (busAddr): 0 index, 1 index-with-prefetch, 2 mask, 3 data port, 4 sequence, 5/6/7 red/green/blue prefetch. Each read or write of address 3 moves the pointer red(0) to green(1) to blue(2). With the format bit clear, an access at blue returns the pointer to red and increments the index. A cycle with no access to address 3 leaves the pointer and index unchanged.
- R3: With the format bit set, an access at blue moves the pointer to extra(3). The access at extra returns it to red and increments the index.
- R4: The sequence register (address 4) reads back bits 1:0 as the pointer (0 red, 1 green, 2 blue, 3 extra), bit 2 as the format bit and the other bits as 0. A write loads both fields from the same bit positions.
- R5: A write to address 0 or address 1 loads the index from busWdata and resets the pointer to red.
- R6: A write to address 1 loads the three prefetch registers from the red, green and blue bytes of the entry named by the written value. The prefetch registers change on no other event, and writes to addresses 5 to 7 are ignored.
- R7: A data-port write changes only the component the pointer selects. The other bytes of the entry keep their values.
- R8: Incrementing the index from 255 gives 0.
- R9: lutRgb equals {red, green, blue} of entry (pixIn AND mask), one clock after pixIn is sampled. Host accesses in that same cycle do not delay it. A host write to the same entry in that same cycle shows up one cycle later.
- R10: The mask register (address 2) is read/write, and the lookup uses its new value from the cycle after the write.
- R11: busRdata is registered and shows the addressed value on the clock after a read request. It holds that value until the next read. Addresses 8 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access request for this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register select |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| pixIn | input | 8 | Display pixel byte |
| lutRgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
The assertions check the following on every cycle:
- the pointer steps forward and wraps correctly in both formats;
- an index write loads the index and resets the pointer;
- the pointer and index stay put when there is no data-port access;
- the prefetch registers stay stable except when the prefetch index is written;
- the read data holds between reads.

The values that pass through the table can only be shown by the bench's scenarios. These are:
- that a write touches a single byte;
- what the prefetch registers capture;
- the masked lookup address and its one-cycle latency when a host write happens in the same cycle;
- the wrap of the index from 255 to 0.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int BYTE_W     = 8;
  localparam int COMP_W     = 2;
  localparam int COMP_N     = 4;
  localparam int DISP_N     = 3;
  localparam int REG_ADDR_W = 4;

  typedef enum logic [COMP_W-1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2,
    COMP_EXTRA = 2'd3
  } comp_e;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_INDEX    = 4'h0,
    REG_INDEX_PF = 4'h1,
    REG_MASK     = 4'h2,
    REG_DATA     = 4'h3,
    REG_SEQ      = 4'h4,
    REG_PF_RED   = 4'h5,
    REG_PF_GREEN = 4'h6,
    REG_PF_BLUE  = 4'h7
  } reg_e;

  typedef struct packed {
    logic  entryWe;
    logic  pfLoad;
    logic  maskWe;
    comp_e comp;
  } dp_ctrl_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0]     busWdata,
  input  logic [BYTE_W-1:0]     hostByte,
  input  logic [BYTE_W-1:0]     pfRed,
  input  logic [BYTE_W-1:0]     pfGreen,
  input  logic [BYTE_W-1:0]     pfBlue,
  input  logic [BYTE_W-1:0]     maskVal,
  output dp_ctrl_t              dpCtrl,
  output logic [IDX_W-1:0]      curIdx,
  output comp_e                 curComp,
  output logic                  fmtExt,
  output logic [BYTE_W-1:0]     busRdata
);
  localparam int SEQ_FMT_BIT = COMP_W;

  reg_e             regSel;
  logic             wrReq;
  logic             rdReq;
  logic             dataAccess;
  logic             idxWrite;
  comp_e            lastComp;
  logic             atEnd;
  logic [BYTE_W-1:0] rdNext;
  logic [IDX_W-1:0] idxQ;
  comp_e            compQ;
  logic             fmtQ;
  logic [BYTE_W-1:0] rdQ;

  assign regSel     = reg_e'(busAddr);
  assign wrReq      = busSel & busWrite;
  assign rdReq      = busSel & ~busWrite;
  assign dataAccess = busSel && (regSel == REG_DATA);
  assign idxWrite   = wrReq && ((regSel == REG_INDEX) || (regSel == REG_INDEX_PF));
  assign lastComp   = fmtQ ? COMP_EXTRA : COMP_BLUE;
  assign atEnd      = (compQ >= lastComp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      compQ <= COMP_RED;
      fmtQ  <= 1'b0;
    end else if (idxWrite) begin
      idxQ  <= busWdata[IDX_W-1:0];
      compQ <= COMP_RED;
    end else if (wrReq && (regSel == REG_SEQ)) begin
      fmtQ  <= busWdata[SEQ_FMT_BIT];
      compQ <= comp_e'(busWdata[COMP_W-1:0]);
    end else if (dataAccess) begin
      if (atEnd) begin
        compQ <= COMP_RED;
        idxQ  <= idxQ + 1'b1;
      end else begin
        compQ <= comp_e'(compQ + 1'b1);
      end
    end
  end

  always_comb begin
    case (regSel)
      REG_INDEX, REG_INDEX_PF: rdNext = BYTE_W'(idxQ);
      REG_MASK:                rdNext = maskVal;
      REG_DATA:                rdNext = hostByte;
      REG_SEQ:                 rdNext = BYTE_W'({fmtQ, compQ});
      REG_PF_RED:              rdNext = pfRed;
      REG_PF_GREEN:            rdNext = pfGreen;
      REG_PF_BLUE:             rdNext = pfBlue;
      default:                 rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdQ <= '0;
    else if (rdReq) rdQ <= rdNext;
  end

  assign dpCtrl.entryWe = wrReq && (regSel == REG_DATA);
  assign dpCtrl.pfLoad  = wrReq && (regSel == REG_INDEX_PF);
  assign dpCtrl.maskWe  = wrReq && (regSel == REG_MASK);
  assign dpCtrl.comp    = compQ;

  assign curIdx   = idxQ;
  assign curComp  = compQ;
  assign fmtExt   = fmtQ;
  assign busRdata = rdQ;
endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dp_ctrl_t                dpCtrl,
  input  logic [IDX_W-1:0]        hostIdx,
  input  logic [BYTE_W-1:0]       busWdata,
  input  logic [BYTE_W-1:0]       pixIn,
  output logic [BYTE_W-1:0]       hostByte,
  output logic [BYTE_W-1:0]       pfRed,
  output logic [BYTE_W-1:0]       pfGreen,
  output logic [BYTE_W-1:0]       pfBlue,
  output logic [BYTE_W-1:0]       maskVal,
  output logic [DISP_N*BYTE_W-1:0] lutRgb
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] hostLane [COMP_N];
  logic [BYTE_W-1:0] pfLane   [DISP_N];
  logic [BYTE_W-1:0] lutLane  [DISP_N];
  logic [BYTE_W-1:0] pfQ      [DISP_N];
  logic [BYTE_W-1:0] maskQ;
  logic [IDX_W-1:0]  pfAddr;
  logic [IDX_W-1:0]  pixAddr;

  assign pfAddr  = busWdata[IDX_W-1:0];
  assign pixAddr = pixIn[IDX_W-1:0] & maskQ[IDX_W-1:0];

  for (genvar g = 0; g < COMP_N; g++) begin : g_lane
    logic [BYTE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (dpCtrl.entryWe && (dpCtrl.comp == comp_e'(g)))
        store[hostIdx] <= busWdata;
    end

    assign hostLane[g] = store[hostIdx];

    if (g < DISP_N) begin : g_disp
      logic [BYTE_W-1:0] lutQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) lutQ <= '0;
        else       lutQ <= store[pixAddr];
      end
      assign lutLane[g] = lutQ;
      assign pfLane[g]  = store[pfAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DISP_N; i++) pfQ[i] <= '0;
    end else if (dpCtrl.pfLoad) begin
      for (int i = 0; i < DISP_N; i++) pfQ[i] <= pfLane[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '1;
    else if (dpCtrl.maskWe) maskQ <= busWdata;
  end

  assign hostByte = hostLane[dpCtrl.comp];
  assign pfRed    = pfQ[0];
  assign pfGreen  = pfQ[1];
  assign pfBlue   = pfQ[2];
  assign maskVal  = maskQ;
  assign lutRgb   = {lutLane[0], lutLane[1], lutLane[2]};
endmodule

// File: rtl/pal_port_seq.sv
module pal_port_seq
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      busSel,
  input  logic                      busWrite,
  input  logic [REG_ADDR_W-1:0]     busAddr,
  input  logic [BYTE_W-1:0]         busWdata,
  output logic [BYTE_W-1:0]         busRdata,
  input  logic [BYTE_W-1:0]         pixIn,
  output logic [DISP_N*BYTE_W-1:0]  lutRgb
);
  dp_ctrl_t          dpCtrl;
  logic [IDX_W-1:0]  curIdx;
  comp_e             curComp;
  logic              fmtExt;
  logic [BYTE_W-1:0] hostByte;
  logic [BYTE_W-1:0] pfRed;
  logic [BYTE_W-1:0] pfGreen;
  logic [BYTE_W-1:0] pfBlue;
  logic [BYTE_W-1:0] maskVal;

  pal_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .hostByte (hostByte),
    .pfRed    (pfRed),
    .pfGreen  (pfGreen),
    .pfBlue   (pfBlue),
    .maskVal  (maskVal),
    .dpCtrl   (dpCtrl),
    .curIdx   (curIdx),
    .curComp  (curComp),
    .fmtExt   (fmtExt),
    .busRdata (busRdata)
  );

  pal_datapath #(.IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .hostIdx  (curIdx),
    .busWdata (busWdata),
    .pixIn    (pixIn),
    .hostByte (hostByte),
    .pfRed    (pfRed),
    .pfGreen  (pfGreen),
    .pfBlue   (pfBlue),
    .maskVal  (maskVal),
    .lutRgb   (lutRgb)
  );
endmodule

// File: rtl/pal_port_seq_chk.sv
module pal_port_seq_chk
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWrite,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0]     busWdata,
  input logic [BYTE_W-1:0]     busRdata,
  input logic [IDX_W-1:0]      curIdx,
  input logic [COMP_W-1:0]     curComp,
  input logic                  fmtExt,
  input logic [BYTE_W-1:0]     pfRed,
  input logic [BYTE_W-1:0]     pfGreen,
  input logic [BYTE_W-1:0]     pfBlue
);
  logic dataAcc;
  logic idxWr;
  logic pfWr;
  assign dataAcc = busSel && (busAddr == REG_DATA);
  assign idxWr   = busSel && busWrite && ((busAddr == REG_INDEX) || (busAddr == REG_INDEX_PF));
  assign pfWr    = busSel && busWrite && (busAddr == REG_INDEX_PF);

  p_wrap_rgb_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !fmtExt && curComp == 2'd2) |=>
      (curComp == 2'd0 && curIdx == IDX_W'($past(curIdx) + 1'b1)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && curComp < 2'd2) |=>
      (curComp == COMP_W'($past(curComp) + 1'b1) && $stable(curIdx)));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |=> ($stable(curIdx) && $stable(curComp)));

  p_extra_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && fmtExt && curComp == 2'd2) |=> (curComp == 2'd3 && $stable(curIdx)));

  p_extra_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && curComp == 2'd3) |=>
      (curComp == 2'd0 && curIdx == IDX_W'($past(curIdx) + 1'b1)));

  p_index_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    idxWr |=> (curComp == 2'd0 && curIdx == $past(busWdata[IDX_W-1:0])));

  p_pf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !pfWr |=> ($stable(pfRed) && $stable(pfGreen) && $stable(pfBlue)));

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWrite) |=> $stable(busRdata));
endmodule

bind pal_port_seq pal_port_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .curIdx   (curIdx),
  .curComp  (curComp),
  .fmtExt   (fmtExt),
  .pfRed    (pfRed),
  .pfGreen  (pfGreen),
  .pfBlue   (pfBlue)
);

// File: tb/pal_port_seq_tb.sv
`timescale 1ns/1ps
module pal_port_seq_tb;
  import pal_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  pixIn = '0;
  logic [23:0] lutRgb;
  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pal_port_seq u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pixIn(pixIn), .lutRgb(lutRgb)
  );

  typedef struct packed {
    logic       isWrite;
    logic [3:0] req;
    logic [3:0] addr;
    logic [7:0] data;
  } vec_t;

  function automatic vec_t wv(input int r, input logic [3:0] a, input logic [7:0] d);
    return {1'b1, 4'(r), a, d};
  endfunction
  function automatic vec_t cv(input int r, input logic [3:0] a, input logic [7:0] e);
    return {1'b0, 4'(r), a, e};
  endfunction

  localparam logic [3:0] A_IDX = 4'h0, A_IPF = 4'h1, A_MSK = 4'h2, A_DAT = 4'h3,
                         A_SEQ = 4'h4, A_PFR = 4'h5, A_PFG = 4'h6, A_PFB = 4'h7;
  localparam int NVEC = 65;
  localparam vec_t VEC [NVEC] = '{
    cv(1, A_IDX, 8'h00), cv(1, A_SEQ, 8'h00), cv(1, A_MSK, 8'hFF),        // R1
    cv(1, A_PFR, 8'h00), cv(1, A_PFB, 8'h00),
    wv(5, A_IDX, 8'h10),                                                  // R5
    wv(2, A_DAT, 8'h11), wv(2, A_DAT, 8'h12), wv(2, A_DAT, 8'h13),        // R2
    cv(2, A_SEQ, 8'h00), cv(2, A_IDX, 8'h11),
    wv(2, A_DAT, 8'h21), cv(2, A_SEQ, 8'h01),
    wv(5, A_IDX, 8'h10), cv(5, A_SEQ, 8'h00),
    cv(2, A_DAT, 8'h11), cv(2, A_DAT, 8'h12), cv(2, A_DAT, 8'h13),
    cv(2, A_IDX, 8'h11),
    wv(4, A_SEQ, 8'h04), cv(4, A_SEQ, 8'h04),                             // R4
    wv(5, A_IDX, 8'h20),
    wv(3, A_DAT, 8'hA0), wv(3, A_DAT, 8'hA1), wv(3, A_DAT, 8'hA2),        // R3
    cv(3, A_SEQ, 8'h07), wv(3, A_DAT, 8'hA3), cv(3, A_IDX, 8'h21),
    wv(5, A_IDX, 8'h20),
    cv(3, A_DAT, 8'hA0), cv(3, A_DAT, 8'hA1), cv(3, A_DAT, 8'hA2),
    cv(3, A_DAT, 8'hA3), cv(3, A_IDX, 8'h21), cv(3, A_SEQ, 8'h04),
    wv(7, A_IDX, 8'h10), wv(4, A_SEQ, 8'h01), cv(4, A_SEQ, 8'h01),        // R7
    wv(7, A_DAT, 8'h55), wv(7, A_IDX, 8'h10),
    cv(7, A_DAT, 8'h11), cv(7, A_DAT, 8'h55), cv(7, A_DAT, 8'h13),
    wv(6, A_IPF, 8'h10),                                                  // R6
    cv(6, A_PFR, 8'h11), cv(6, A_PFG, 8'h55), cv(6, A_PFB, 8'h13),
    cv(5, A_SEQ, 8'h00), cv(5, A_IDX, 8'h10),
    wv(6, A_PFR, 8'hEE), cv(6, A_PFR, 8'h11),
    wv(5, A_SEQ, 8'h02), wv(5, A_IPF, 8'h20), cv(5, A_SEQ, 8'h00),
    cv(6, A_PFG, 8'hA1),
    wv(10, A_MSK, 8'h3C), cv(10, A_MSK, 8'h3C), wv(10, A_MSK, 8'hFF),     // R10
    cv(11, 4'h9, 8'h00),                                                  // R11
    wv(8, A_IDX, 8'hFF),                                                  // R8
    wv(8, A_DAT, 8'h71), wv(8, A_DAT, 8'h72), wv(8, A_DAT, 8'h73),
    cv(8, A_IDX, 8'h00), cv(8, A_SEQ, 8'h00)
  };

  task automatic chk(input int req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, output logic [7:0] q);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busSel = 1'b0;
    q = busRdata;
  endtask

  task automatic pixChk(input int req, input logic [7:0] p, input logic [23:0] exp);
    @(negedge clk);
    pixIn = p;
    @(negedge clk);
    chk(req, "lookup", lutRgb, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(1, "reset lutRgb", lutRgb, 24'h0);   // R1
    chk(1, "reset busRdata", busRdata, 8'h00);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWrite) begin
        busWr(VEC[i].addr, VEC[i].data);
      end else begin
        busRd(VEC[i].addr, q);
        chk(int'(VEC[i].req), $sformatf("vector %0d read", i), q, VEC[i].data);
      end
    end

    // R9: masked lookup, one-cycle latency, host write in the same cycle
    pixChk(9, 8'h10, 24'h115513);
    pixChk(9, 8'hFF, 24'h717273);
    busWr(A_IDX, 8'h20);
    @(negedge clk);
    pixIn = 8'h20; busSel = 1'b1; busWrite = 1'b1; busAddr = A_DAT; busWdata = 8'h5A;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    chk(9, "lookup during host write", lutRgb, 24'hA0A1A2);
    @(negedge clk);
    chk(9, "lookup after host write", lutRgb, 24'h5AA1A2);

    // R10: mask applied to the lookup address
    busWr(A_MSK, 8'hE0);
    pixChk(10, 8'h3F, 24'h5AA1A2);
    busWr(A_MSK, 8'hF0);
    pixChk(10, 8'h1F, 24'h115513);
    busWr(A_MSK, 8'hFF);

    // R11: read data holds across idle cycles and writes
    busRd(A_PFG, held);
    chk(11, "read value", held, 8'hA1);
    repeat (3) @(negedge clk);
    busWr(A_MSK, 8'h77);
    chk(11, "read data hold", busRdata, 8'hA1);

    summary();
    $finish;
  end
endmodule